// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

This block keeps a four-bank SDRAM refreshed on behalf of a data-path controller. A free-running interval timer marks each refresh period. When a period expires, the owed refresh is held as pending and the block asks the controller for the command bus. Once the bus is granted, the block closes any open rows with a precharge-all if needed. It then issues one auto refresh and pads the bus with NOPs for the row cycle time. Finally it hands the bus back with a one-cycle done pulse.

On request, the block also takes the device into self refresh. It precharges first if any bank is open, then drops CKE together with the self-refresh command and keeps CKE low until an exit request arrives. After exit it raises CKE and waits a full row cycle of NOPs. It then issues a catch-up burst of back-to-back auto refreshes, each followed by a row cycle of NOPs, before it returns the bus. All timing values are parameters counted in whole clock cycles. Commands are driven as the active-low chip select, row strobe, column strobe and write enable, plus the address bit that selects precharge-all.

Top module: `sdram_refresh_sched`

## Requirements
- R1: During and straight after reset, the command is NOP (`cmd_o` = 4'b0111, bits ordered cs_n, ras_n, cas_n, we_n), `cke_o` is 1, and `a10_o`, `req_o` and `done_o` are 0.
- R2: If the bus is always granted and all banks are idle, auto refreshes (`cmd_o` = 4'b0001 with `cke_o` = 1) are spaced exactly `INTERVAL` cycles apart. The first comes `INTERVAL`+2 cycles after reset is released.
- R3: A due refresh raises `req_o` and issues no command until `grant_i` is seen. The refresh follows in the cycle after grant is sampled high. It is never lost while waiting, and periods that expire during the wait merge into that single refresh.
- R4: If `banks_idle_i` is 0 when the grant is sampled, the block first issues precharge-all (`cmd_o` = 4'b0010 with `a10_o` = 1). The next command (refresh or self-refresh entry) follows exactly `T_RP` cycles later.
- R5: Each auto refresh is followed by NOPs, and the next command or done pulse comes exactly `T_RC` cycles after the refresh.
- R6: `done_o` is high for exactly one cycle, `T_RC` cycles after the last refresh of a sequence, with `req_o` low and a NOP on the bus.
- R7: When `sr_enter_i` is high at grant, the block enters self refresh. It drives `cmd_o` = 4'b0001 with `cke_o` falling to 0 in the same cycle, and the self-refresh request takes priority over a pending periodic refresh.
- R8: While in self refresh, `cke_o` stays 0, `req_o` stays 1 and only NOPs are driven. Timer expiries during this time cause no command.
- R9: `cke_o` rises in the cycle after `sr_exit_i` is sampled high. The first auto refresh follows `T_RC` cycles after the rise. A burst of `BURST` refreshes then runs, spaced `T_RC` apart, and done comes `T_RC` after the last one.
- R10: Every auto refresh is issued with `cke_o` high in both that cycle and the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| banks_idle_i | input | 1 | High when every bank is precharged |
| grant_i | input | 1 | Command bus granted to this block |
| sr_enter_i | input | 1 | Level request to enter self refresh |
| sr_exit_i | input | 1 | Request to leave self refresh |
| req_o | output | 1 | Bus request, held until the bus is handed back |
| done_o | output | 1 | One-cycle pulse when the bus is handed back |
| cke_o | output | 1 | SDRAM clock enable |
| cmd_o | output | 4 | Command {cs_n, ras_n, cas_n, we_n} |
| a10_o | output | 1 | Address bit 10, high for precharge-all |

## Verification
Every result of this block lands a fixed number of cycles after its cause. A refresh lands two cycles after the timer expiry is registered, or one cycle after grant is sampled. The command after a precharge lands `T_RP` later and the command after a refresh `T_RC` later. Self-refresh entry lands two cycles after a request is raised in idle, and the CKE rise one cycle after the exit request. The bench works out each of these absolute cycle numbers from its own count of clock edges since reset release and queues them with the expected event kind. A monitor samples on the falling edge, turns every non-NOP command, CKE edge or done pulse into an event, and compares its kind and cycle with the head of the queue. Any extra, missing or late event is therefore reported.

// File: rtl/sdram_ref_pkg.sv
package sdram_ref_pkg;

  // Command bits ordered {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;  // self refresh when CKE falls with it

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_REQ,
    ST_PRE,
    ST_WRP,
    ST_REF,
    ST_WRC,
    ST_DONE,
    ST_SRE,
    ST_SR,
    ST_SRX
  } ref_state_e;

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int INTERVAL = 1560
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          wrap;

  always_comb begin
    wrap   = (cnt_q == CW'(INTERVAL - 1));
    cnt_en = 1'b1;
    cnt_d  = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign tick_o = wrap;

  // R2: expiries are isolated single-cycle marks
  p_tick_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

endmodule

// File: rtl/ref_wait_cnt.sv
module ref_wait_cnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? val_i : cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == W'(1));

endmodule

// File: rtl/ref_burst_cnt.sv
module ref_burst_cnt #(
  parameter int BURST = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic dec_i,
  output logic zero_o
);
  localparam int BW = $clog2(BURST + 1);

  logic [BW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i || dec_i;
    cnt_d  = load_i ? BW'(BURST) : cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  // R9: the burst never counts past its end
  p_burst_underflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> !zero_o);

endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
  import sdram_ref_pkg::*;
#(
  parameter int INTERVAL = 1560,
  parameter int T_RC     = 7,
  parameter int T_RP     = 2,
  parameter int BURST    = 4096
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       banks_idle_i,
  input  logic       grant_i,
  input  logic       sr_enter_i,
  input  logic       sr_exit_i,
  output logic       req_o,
  output logic       done_o,
  output logic       cke_o,
  output logic [3:0] cmd_o,
  output logic       a10_o
);
  localparam int WMAX = (T_RC > T_RP) ? T_RC : T_RP;
  localparam int WW   = $clog2(WMAX + 1);

  ref_state_e    state_q, state_d;
  logic          pend_q, pend_d;
  logic          sr_tgt_q, sr_tgt_d;
  logic          tick;
  logic          wc_load, wc_last;
  logic [WW-1:0] wc_val;
  logic          bc_load, bc_dec, bc_zero;

  ref_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  ref_wait_cnt #(.W(WW)) u_wait (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (wc_load),
    .val_i  (wc_val),
    .last_o (wc_last)
  );

  ref_burst_cnt #(.BURST(BURST)) u_burst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (bc_load),
    .dec_i  (bc_dec),
    .zero_o (bc_zero)
  );

  // Owed refresh: set by the timer, cleared when a refresh goes out
  always_comb begin
    if (tick)                  pend_d = 1'b1;
    else if (state_q == ST_REF) pend_d = 1'b0;
    else                       pend_d = pend_q;
  end

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    sr_tgt_d = sr_tgt_q;
    wc_load  = 1'b0;
    wc_val   = '0;
    bc_load  = 1'b0;
    bc_dec   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (sr_enter_i || pend_q) state_d = ST_REQ;
      end
      ST_REQ: begin
        if (grant_i) begin
          sr_tgt_d = sr_enter_i;
          if (!banks_idle_i)   state_d = ST_PRE;
          else if (sr_enter_i) state_d = ST_SRE;
          else                 state_d = ST_REF;
        end
      end
      ST_PRE: begin
        wc_load = 1'b1;
        wc_val  = WW'(T_RP - 1);
        state_d = ST_WRP;
      end
      ST_WRP: begin
        if (wc_last) state_d = sr_tgt_q ? ST_SRE : ST_REF;
      end
      ST_REF: begin
        wc_load = 1'b1;
        wc_val  = WW'(T_RC - 1);
        bc_dec  = !bc_zero;
        state_d = ST_WRC;
      end
      ST_WRC: begin
        if (wc_last) state_d = bc_zero ? ST_DONE : ST_REF;
      end
      ST_DONE: begin
        sr_tgt_d = 1'b0;
        state_d  = ST_IDLE;
      end
      ST_SRE: begin
        state_d = ST_SR;
      end
      ST_SR: begin
        if (sr_exit_i) begin
          wc_load = 1'b1;
          wc_val  = WW'(T_RC);
          bc_load = 1'b1;
          state_d = ST_SRX;
        end
      end
      ST_SRX: begin
        if (wc_last) state_d = ST_REF;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      pend_q   <= 1'b0;
      sr_tgt_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      pend_q   <= pend_d;
      sr_tgt_q <= sr_tgt_d;
    end
  end

  // Moore outputs decoded from the state register
  always_comb begin
    unique case (state_q)
      ST_PRE:         cmd_o = CMD_PRE;
      ST_REF, ST_SRE: cmd_o = CMD_REF;
      default:        cmd_o = CMD_NOP;
    endcase
    a10_o  = (state_q == ST_PRE);
    cke_o  = !(state_q inside {ST_SRE, ST_SR});
    req_o  = !(state_q inside {ST_IDLE, ST_DONE});
    done_o = (state_q == ST_DONE);
  end

  // R3: nothing is driven while the bus is not held
  p_quiet_unheld_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o |-> (cmd_o == CMD_NOP) && cke_o);

  // R4: precharge-all is followed by a NOP gap
  p_pre_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_PRE) |=> (cmd_o == CMD_NOP) && !done_o);

  // R5: a refresh is followed by NOP
  p_ref_pad_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmd_o == CMD_REF) && cke_o) |=> (cmd_o == CMD_NOP));

  // R6: handback is a single-cycle pulse with the bus released
  p_done_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !req_o && (cmd_o == CMD_NOP));
  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7: CKE only falls together with the self-refresh command
  p_sr_entry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_o) |-> (cmd_o == CMD_REF) && req_o);

  // R8: bus stays silent while CKE remains low
  p_sr_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_o && $past(!cke_o)) |-> (cmd_o == CMD_NOP) && req_o);

  // R10: CKE high in the cycle before any auto refresh
  p_ref_cke_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmd_o == CMD_REF) && cke_o) |-> $past(cke_o));

endmodule

// File: tb/test_sdram_refresh_sched.sv
module test_sdram_refresh_sched;
  localparam int INTERVAL = 200;
  localparam int T_RC     = 7;
  localparam int T_RP     = 3;
  localparam int BURST    = 8;

  localparam int EV_PRE  = 0;
  localparam int EV_REF  = 1;
  localparam int EV_SRE  = 2;
  localparam int EV_SRX  = 3;
  localparam int EV_DONE = 4;
  localparam int EV_BAD  = 5;

  typedef struct {
    int    kind;
    int    cyc;
    string tag;
  } exp_t;

  logic       clk;
  logic       rst_n;
  logic       banks_idle, grant, sr_enter, sr_exit;
  logic       req, done, cke, a10;
  logic [3:0] cmd;

  int   cyc;
  int   n_cmp;
  int   n_bad;
  exp_t expq[$];
  logic prev_cke;
  int   rel;

  sdram_refresh_sched #(
    .INTERVAL(INTERVAL), .T_RC(T_RC), .T_RP(T_RP), .BURST(BURST)
  ) i_sdram_refresh_sched (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .banks_idle_i (banks_idle),
    .grant_i      (grant),
    .sr_enter_i   (sr_enter),
    .sr_exit_i    (sr_exit),
    .req_o        (req),
    .done_o       (done),
    .cke_o        (cke),
    .cmd_o        (cmd),
    .a10_o        (a10)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic string ev_name(int k);
    case (k)
      EV_PRE:  return "PRE";
      EV_REF:  return "REF";
      EV_SRE:  return "SELF";
      EV_SRX:  return "CKE_UP";
      EV_DONE: return "DONE";
      default: return "BAD";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %s expected %s (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic push_exp(input int kind, input int at, input string tag);
    exp_t e;
    e.kind = kind;
    e.cyc  = at;
    e.tag  = tag;
    expq.push_back(e);
  endtask

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // Monitor: turn bus activity into events and compare with the queue
  task automatic observe(input int kind);
    exp_t e;
    if (expq.size() == 0) begin
      check(1'b0, "unexpected", $sformatf("%s@%0d", ev_name(kind), cyc), "no event");
    end else begin
      e = expq.pop_front();
      check(e.kind == kind && e.cyc == cyc, e.tag,
            $sformatf("%s@%0d", ev_name(kind), cyc),
            $sformatf("%s@%0d", ev_name(e.kind), e.cyc));
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd == 4'b0010 && a10)           observe(EV_PRE);
      else if (cmd == 4'b0001 && cke)      observe(EV_REF);
      else if (cmd == 4'b0001 && !cke)     observe(EV_SRE);
      else if (cmd != 4'b0111)             observe(EV_BAD);
      if (cke && !prev_cke)                observe(EV_SRX);
      if (done)                            observe(EV_DONE);
    end
    prev_cke = cke;
  end

  // Watchdog
  initial begin
    wait (cyc == 5000);
    n_bad++;
    $display("FAIL watchdog: actual cycle %0d expected finish before 5000", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    n_cmp = 0;
    n_bad = 0;
    prev_cke = 1'b1;
    rst_n = 1'b0;
    banks_idle = 1'b1;
    grant = 1'b1;
    sr_enter = 1'b0;
    sr_exit = 1'b0;

    wait_cyc(2);
    // R1: outputs while in reset
    check(cmd == 4'b0111 && cke && !a10 && !req && !done, "R1 in reset",
          $sformatf("cmd=%b cke=%b a10=%b req=%b done=%b", cmd, cke, a10, req, done),
          "cmd=0111 cke=1 a10=0 req=0 done=0");
    wait_cyc(3);
    rst_n = 1'b1;
    rel = 3;
    wait_cyc(4);
    check(cmd == 4'b0111 && cke && !a10 && !req && !done, "R1 after release",
          $sformatf("cmd=%b cke=%b a10=%b req=%b done=%b", cmd, cke, a10, req, done),
          "cmd=0111 cke=1 a10=0 req=0 done=0");

    // R2, R5, R6: periodic refresh with free bus
    push_exp(EV_REF,  rel + INTERVAL + 2,            "R2 first refresh");
    push_exp(EV_DONE, rel + INTERVAL + 2 + T_RC,     "R5/R6 done after tRC");
    push_exp(EV_REF,  rel + 2*INTERVAL + 2,          "R2 interval spacing");
    push_exp(EV_DONE, rel + 2*INTERVAL + 2 + T_RC,   "R6 done pulse");

    // R4: banks open when slot 3 comes
    wait_cyc(500);
    banks_idle = 1'b0;
    push_exp(EV_PRE,  rel + 3*INTERVAL + 2,               "R4 precharge-all");
    push_exp(EV_REF,  rel + 3*INTERVAL + 2 + T_RP,        "R4 refresh after tRP");
    push_exp(EV_DONE, rel + 3*INTERVAL + 2 + T_RP + T_RC, "R5 done after tRC");
    wait_cyc(620);
    banks_idle = 1'b1;

    // R3: bus withheld across two expiries
    wait_cyc(700);
    grant = 1'b0;
    wait_cyc(900);
    check(req && cmd == 4'b0111, "R3 request held without grant",
          $sformatf("req=%b cmd=%b", req, cmd), "req=1 cmd=0111");
    wait_cyc(1020);
    grant = 1'b1;
    push_exp(EV_REF,  1021,        "R3 refresh after grant");
    push_exp(EV_DONE, 1021 + T_RC, "R3 single merged refresh");
    push_exp(EV_REF,  rel + 6*INTERVAL + 2,        "R2 phase kept after wait");
    push_exp(EV_DONE, rel + 6*INTERVAL + 2 + T_RC, "R6 done pulse");

    // R7, R8, R9: self refresh with an open bank
    wait_cyc(1250);
    banks_idle = 1'b0;
    wait_cyc(1300);
    sr_enter = 1'b1;
    push_exp(EV_PRE, 1302,        "R4 precharge before self refresh");
    push_exp(EV_SRE, 1302 + T_RP, "R7 self refresh entry");
    wait_cyc(1310);
    sr_enter = 1'b0;
    banks_idle = 1'b1;
    wait_cyc(1500);
    check(!cke && req && cmd == 4'b0111, "R8 held in self refresh",
          $sformatf("cke=%b req=%b cmd=%b", cke, req, cmd), "cke=0 req=1 cmd=0111");
    wait_cyc(1610);
    sr_exit = 1'b1;
    push_exp(EV_SRX, 1611, "R9 cke rises after exit");
    for (int k = 0; k < BURST; k++)
      push_exp(EV_REF, 1611 + T_RC + k*T_RC, "R9 burst refresh R10");
    push_exp(EV_DONE, 1611 + T_RC + BURST*T_RC, "R9 done after burst");
    push_exp(EV_REF,  rel + 9*INTERVAL + 2,        "R2 periodic resumes");
    push_exp(EV_DONE, rel + 9*INTERVAL + 2 + T_RC, "R6 done pulse");
    wait_cyc(1612);
    sr_exit = 1'b0;

    wait_cyc(1850);
    check(expq.size() == 0, "R9 all events seen",
          $sformatf("%0d left", expq.size()), "0 left");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule